// File: doc/BRIEF.md
# Burst-Four Split-Port Synchronous Memory

This block is a synchronous memory with one data bus for reads and a separate one for writes. The two buses never share wires, so no cycle is spent turning a bus around. A single address bus is shared in time. Every frame of the block has one read address slot followed by one write address slot. Each address names a line of four data words. A read streams the four words out, and a write takes four words in. Reads and writes can overlap freely.

Words move at double rate. Two words are moved in every cycle of the notional input clock. For synthesis, this is modelled with one clock `clk` that runs at twice that rate, together with a two-bit slot counter that the block drives out on `slot`:

- Even slot values stand for rising edges of the input clock.
- Odd slot values stand for rising edges of its complement.
- One frame is four `clk` cycles, slots 0 to 3.

Each write beat carries one enable bit per byte lane. A read always returns the newest data. A write that is still collecting beats when a later read of the same line is fetched is forwarded straight to that read.

Top module: `qdr_burst_sram`

## Requirements
- R1: After reset, `slot` steps 0,1,2,3,0,… once per `clk` cycle. The read address and `rd_sel_n` are sampled only at the edge that ends slot 0. The write address and `wr_sel_n` are sampled only at the edge that ends slot 2. Select values and addresses in any other slot have no effect.
- R2: For an accepted write, the write-data beats sampled at the edges ending slots 2, 3, 0 and 1 (in that order) are stored as words 0, 1, 2 and 3 of the addressed line.
- R3: For an accepted read, word j of the line is on `rd_data` with `rd_valid` high while `slot` reads j in the next frame. The first word therefore follows the read address edge by three `clk` cycles, which is one and a half input-clock periods.
- R4: Bit i of `wr_be` enables byte lane i of the word, at bits [i*L +: L]. L is 9 when DW is a multiple of 9 and 8 otherwise. Lanes whose bit is clear keep their stored value.
- R5: A write slot with `wr_sel_n` high leaves the whole array unchanged, whatever is on `wr_data` and `wr_be`.
- R6: A read slot with `rd_sel_n` high gives four beats with `rd_valid` low.
- R7: A read in the frame right after a write to the same line returns all four newly written words. This includes the last beat, which arrives after the read address.
- R8: A read does not see a write whose address slot comes later in the same frame, even if it is to the same line.
- R9: While `rst` is high, the next edge sets `slot` to 0 and `rd_valid` to 0.
- R10: A read and a write to different lines can be accepted in the same frame, and each completes unaffected by the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Double-rate clock; each rising edge is one data beat |
| rst | input | 1 | Synchronous active-high reset |
| slot | output | 2 | Current slot in the frame (0 read address, 2 write address) |
| addr | input | AW | Shared line address, read or write by slot |
| rd_sel_n | input | 1 | Active-low read select, sampled in slot 0 |
| wr_sel_n | input | 1 | Active-low write select, sampled in slot 2 |
| wr_data | input | DW | Write data beat |
| wr_be | input | DW/L | Per-lane write enables for the current beat |
| rd_data | output | DW | Read data beat |
| rd_valid | output | 1 | High while `rd_data` carries a read beat |

## Verification
The two functions that can fall on the same edge are these: the last beat of a write is merged into the array, and the line for the read that began one cycle earlier is fetched. The bench provokes this in two ways. First, it writes a line in one frame and reads that same line in the next frame. Second, it pairs a read with a write to the same line inside a single frame, where the read must return the older data. Every beat is judged against a reference memory. The bench updates that memory only with writes whose address slot comes before the read, and applies the lane masks word by word. Both selects are driven low with false addresses in the slots that must ignore them.

// File: rtl/qdr_pkg.sv
package qdr_pkg;

    // Words moved per address: two per input-clock cycle, over two cycles.
    localparam int BEATS = 4;

    // Position inside one frame of four double-rate beats.
    typedef enum logic [1:0] {
        SLOT_RD      = 2'd0,   // input clock rise: read address
        SLOT_RD_LATE = 2'd1,   // complement rise
        SLOT_WR      = 2'd2,   // input clock rise: write address
        SLOT_WR_LATE = 2'd3    // complement rise
    } slot_e;

    // Byte lane width: 9-bit lanes carry parity-style widths.
    function automatic int lane_width(int dw);
        return (dw % 9 == 0) ? 9 : 8;
    endfunction

endpackage

// File: rtl/qdr_slot_timer.sv
module qdr_slot_timer (
    input  logic            clk,
    input  logic            rst,
    output qdr_pkg::slot_e  slot
);
    import qdr_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) slot <= SLOT_RD;
        else     slot <= slot_e'(slot + 2'd1);
    end

    // R1: the slot advances by one on every cycle out of reset
    p_slot_step_r1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> slot == slot_e'($past(slot) + 2'd1));

endmodule

// File: rtl/qdr_write_gather.sv
module qdr_write_gather #(
    parameter int AW = 8,
    parameter int DW = 18,
    parameter int NL = 2
) (
    input  logic                              clk,
    input  logic                              rst,
    input  qdr_pkg::slot_e                    slot,
    input  logic [AW-1:0]                     addr,
    input  logic                              wr_sel_n,
    input  logic [DW-1:0]                     wr_data,
    input  logic [NL-1:0]                     wr_be,
    output logic                              commit,
    output logic [AW-1:0]                     commit_addr,
    output logic [qdr_pkg::BEATS-1:0][DW-1:0] commit_data,
    output logic [qdr_pkg::BEATS-1:0][DW-1:0] commit_mask
);
    import qdr_pkg::*;

    localparam int LW = DW / NL;

    typedef struct packed {
        logic          act;
        logic [AW-1:0] addr;
    } wreq_t;

    wreq_t                          wr_q;
    logic [BEATS-2:0][DW-1:0]       beat_q;
    logic [BEATS-2:0][NL-1:0]       be_q;
    logic [BEATS-1:0][NL-1:0]       be_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q   <= '0;
            beat_q <= '0;
            be_q   <= '0;
        end else begin
            unique case (slot)
                SLOT_WR: begin
                    wr_q.act  <= !wr_sel_n;
                    wr_q.addr <= addr;
                    beat_q[0] <= wr_data;
                    be_q[0]   <= wr_be;
                end
                SLOT_WR_LATE: begin
                    beat_q[1] <= wr_data;
                    be_q[1]   <= wr_be;
                end
                SLOT_RD: begin
                    beat_q[2] <= wr_data;
                    be_q[2]   <= wr_be;
                end
                SLOT_RD_LATE: wr_q.act <= 1'b0;
            endcase
        end
    end

    // The final beat is merged straight from the input on the commit edge.
    assign commit      = wr_q.act && (slot == SLOT_RD_LATE);
    assign commit_addr = wr_q.addr;
    assign commit_data = {wr_data, beat_q};
    assign be_full     = {wr_be, be_q};

    for (genvar b = 0; b < BEATS; b++) begin : g_beat
        for (genvar l = 0; l < NL; l++) begin : g_lane
            assign commit_mask[b][l*LW +: LW] = {LW{be_full[b][l]}};
        end
    end

    // R5: a commit only ever follows a write slot whose select was low
    p_idle_write_r5: assert property (@(posedge clk) disable iff (rst)
        commit |-> !$past(wr_sel_n, 3));

endmodule

// File: rtl/qdr_store.sv
module qdr_store #(
    parameter int AW = 8,
    parameter int DW = 18
) (
    input  logic                              clk,
    input  logic                              we,
    input  logic [AW-1:0]                     waddr,
    input  logic [qdr_pkg::BEATS-1:0][DW-1:0] wdata,
    input  logic [qdr_pkg::BEATS-1:0][DW-1:0] wmask,
    input  logic [AW-1:0]                     raddr,
    output logic [qdr_pkg::BEATS-1:0][DW-1:0] rline
);
    import qdr_pkg::*;

    localparam int LINES = 1 << AW;

    logic [BEATS-1:0][DW-1:0] mem [LINES];
    logic [BEATS-1:0][DW-1:0] merged;

    assign merged = (mem[waddr] & ~wmask) | (wdata & wmask);

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= merged;
    end

    // Bypass: a line fetched on its own commit edge takes the merged value.
    assign rline = (we && (waddr == raddr)) ? merged : mem[raddr];

endmodule

// File: rtl/qdr_read_out.sv
module qdr_read_out #(
    parameter int DW = 18
) (
    input  logic                              clk,
    input  logic                              rst,
    input  qdr_pkg::slot_e                    slot,
    input  logic                              req_act,
    input  logic [qdr_pkg::BEATS-1:0][DW-1:0] rline,
    output logic [DW-1:0]                     rd_data,
    output logic                              rd_valid
);
    import qdr_pkg::*;

    logic [BEATS-1:0][DW-1:0] snap;
    logic                     snap_v;
    logic [BEATS-1:1][DW-1:0] hold;
    logic                     hold_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            snap     <= '0;
            snap_v   <= 1'b0;
            hold     <= '0;
            hold_v   <= 1'b0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            unique case (slot)
                SLOT_RD_LATE: begin
                    snap     <= rline;
                    snap_v   <= req_act;
                    rd_data  <= hold[2];
                    rd_valid <= hold_v;
                end
                SLOT_WR: begin
                    rd_data  <= hold[3];
                    rd_valid <= hold_v;
                end
                SLOT_WR_LATE: begin
                    rd_data  <= snap[0];
                    rd_valid <= snap_v;
                    hold     <= snap[BEATS-1:1];
                    hold_v   <= snap_v;
                end
                SLOT_RD: begin
                    rd_data  <= hold[1];
                    rd_valid <= hold_v;
                end
            endcase
        end
    end

    // R3: once begun, a burst stays valid until its fourth beat
    p_burst_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && slot != SLOT_WR_LATE) |=> rd_valid);

    // R3: a burst can only open at the start of a frame
    p_burst_start_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_valid) |-> slot == SLOT_RD);

endmodule

// File: rtl/qdr_burst_sram.sv
module qdr_burst_sram #(
    parameter int AW = 8,
    parameter int DW = 18
) (
    input  logic                                    clk,
    input  logic                                    rst,
    output logic [1:0]                              slot,
    input  logic [AW-1:0]                           addr,
    input  logic                                    rd_sel_n,
    input  logic                                    wr_sel_n,
    input  logic [DW-1:0]                           wr_data,
    input  logic [DW/qdr_pkg::lane_width(DW)-1:0]   wr_be,
    output logic [DW-1:0]                           rd_data,
    output logic                                    rd_valid
);
    import qdr_pkg::*;

    localparam int LW = lane_width(DW);
    localparam int NL = DW / LW;

    typedef struct packed {
        logic          act;
        logic [AW-1:0] addr;
    } rreq_t;

    slot_e                    slot_q;
    rreq_t                    rd_q;
    logic                     commit;
    logic [AW-1:0]            commit_addr;
    logic [BEATS-1:0][DW-1:0] commit_data;
    logic [BEATS-1:0][DW-1:0] commit_mask;
    logic [BEATS-1:0][DW-1:0] rline;

    qdr_slot_timer u_timer (
        .clk  (clk),
        .rst  (rst),
        .slot (slot_q)
    );

    assign slot = slot_q;

    always_ff @(posedge clk) begin
        if (rst)                  rd_q <= '0;
        else if (slot_q == SLOT_RD) begin
            rd_q.act  <= !rd_sel_n;
            rd_q.addr <= addr;
        end
    end

    qdr_write_gather #(.AW(AW), .DW(DW), .NL(NL)) u_gather (
        .clk         (clk),
        .rst         (rst),
        .slot        (slot_q),
        .addr        (addr),
        .wr_sel_n    (wr_sel_n),
        .wr_data     (wr_data),
        .wr_be       (wr_be),
        .commit      (commit),
        .commit_addr (commit_addr),
        .commit_data (commit_data),
        .commit_mask (commit_mask)
    );

    qdr_store #(.AW(AW), .DW(DW)) u_store (
        .clk   (clk),
        .we    (commit),
        .waddr (commit_addr),
        .wdata (commit_data),
        .wmask (commit_mask),
        .raddr (rd_q.addr),
        .rline (rline)
    );

    qdr_read_out #(.DW(DW)) u_out (
        .clk      (clk),
        .rst      (rst),
        .slot     (slot_q),
        .req_act  (rd_q.act),
        .rline    (rline),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    // R6: a burst opens only for a read slot whose select was low
    p_idle_read_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_valid) |-> !$past(rd_sel_n, 4));

    // R9: reset returns the frame to its start with no read beat showing
    p_reset_state_r9: assert property (@(posedge clk)
        rst |=> (!rd_valid && slot_q == SLOT_RD));

endmodule

// File: tb/sim_qdr_burst_sram.sv
module sim_qdr_burst_sram;

    localparam int AW = 3;
    localparam int DW = 18;
    localparam int LW = 9;
    localparam int NL = 2;
    localparam int NF = 96;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    slot;
    logic [AW-1:0] addr = '0;
    logic          rd_sel_n = 1'b1;
    logic          wr_sel_n = 1'b1;
    logic [DW-1:0] wr_data = '0;
    logic [NL-1:0] wr_be = '0;
    logic [DW-1:0] rd_data;
    logic          rd_valid;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    qdr_burst_sram #(.AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst(rst), .slot(slot), .addr(addr),
        .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
        .wr_data(wr_data), .wr_be(wr_be),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    // Frame plans
    logic          p_rd_en [NF];
    logic [AW-1:0] p_rd_a  [NF];
    logic          p_wr_en [NF];
    logic [AW-1:0] p_wr_a  [NF];
    logic [DW-1:0] p_d     [NF][4];
    logic [NL-1:0] p_be    [NF][4];
    string         p_tag   [NF];
    int            nf = 0;

    logic [DW-1:0] ref_mem  [1<<AW][4];
    logic [DW-1:0] exp_prev [4];
    logic [DW-1:0] exp_cur  [4];

    function automatic logic [DW-1:0] gen(int f, int k);
        return DW'((f * 7919 + k * 389 + 1234) ^ (f << 9) ^ (k << 14));
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // be_mode < 0: all lanes; otherwise lanes rotate per beat
    task automatic add(logic re, int ra, logic we, int wa, int be_mode, string tag);
        p_rd_en[nf] = re;
        p_rd_a[nf]  = AW'(ra);
        p_wr_en[nf] = we;
        p_wr_a[nf]  = AW'(wa);
        for (int k = 0; k < 4; k++) begin
            p_d[nf][k]  = gen(nf, k);
            p_be[nf][k] = (be_mode < 0) ? '1 : NL'((be_mode + k) % 4);
        end
        p_tag[nf] = tag;
        nf++;
    endtask

    task automatic apply_write(int f);
        if (p_wr_en[f])
            for (int k = 0; k < 4; k++)
                for (int l = 0; l < NL; l++)
                    if (p_be[f][k][l])
                        ref_mem[p_wr_a[f]][k][l*LW +: LW] = p_d[f][k][l*LW +: LW];
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        for (int a = 0; a < (1 << AW); a++)
            for (int k = 0; k < 4; k++) ref_mem[a][k] = '0;
        for (int k = 0; k < 4; k++) begin
            exp_prev[k] = '0;
            exp_cur[k]  = '0;
        end

        // R2: fill every line, no reads (idle reads also exercise R6)
        for (int i = 0; i < 8; i++) add(1'b0, 0, 1'b1, i, -1, "R2");
        // R2 and R3: read back every line while write slots are idle
        for (int i = 0; i < 8; i++) add(1'b1, i, 1'b0, i, -1, "R2/R3");
        // R10: concurrent read and write to different lines
        for (int i = 0; i < 8; i++) add(1'b1, i, 1'b1, (i + 3) % 8, -1, "R10");
        // R4: lane-masked writes, read two frames later from the array
        for (int i = 0; i < 16; i++) add(1'b1, (i + 6) % 8, 1'b1, i % 8, i % 4, "R4");
        // R7: read the line written in the previous frame (forwarding)
        for (int i = 0; i < 8; i++) add(1'b1, (i + 7) % 8, 1'b1, i, i % 3 == 0 ? 1 : -1, "R7");
        // R8: same-frame write to the line being read stays invisible
        for (int i = 0; i < 8; i++) add(1'b1, i, 1'b1, i, -1, "R8");
        // R6 and R5: idle reads, idle writes carrying full-lane junk
        for (int i = 0; i < 8; i++) add(1'b0, i, 1'b0, i, -1, "R6");
        // R5: every line must be unchanged by the idle writes
        for (int i = 0; i < 8; i++) add(1'b1, i, 1'b0, 0, -1, "R5");
        add(1'b0, 0, 1'b0, 0, -1, "drain");

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 slot", 32'(slot), 32'd0);
        chk("R9 rd_valid", 32'(rd_valid), 32'd0);
        rst = 1'b0;

        for (int f = 0; f < nf; f++) begin
            for (int j = 0; j < 4; j++) begin
                chk("R1 slot", 32'(slot), 32'(j));
                if (f > 0) begin
                    if (p_rd_en[f-1])
                        chk(p_tag[f-1], {13'd0, rd_valid, rd_data}, {13'd0, 1'b1, exp_prev[j]});
                    else
                        chk("R6", 32'(rd_valid), 32'd0);
                end
                if (j == 0) begin
                    if (f > 0) apply_write(f - 1);
                    for (int k = 0; k < 4; k++) exp_cur[k] = ref_mem[p_rd_a[f]][k];
                end
                // R1: selects held low with false addresses outside their slots
                unique case (j)
                    0: begin
                        addr     = p_rd_a[f];
                        rd_sel_n = !p_rd_en[f];
                        wr_sel_n = 1'b0;
                        wr_data  = (f > 0) ? p_d[f-1][2] : '1;
                        wr_be    = (f > 0) ? p_be[f-1][2] : '1;
                    end
                    1: begin
                        addr     = ~p_rd_a[f];
                        rd_sel_n = 1'b0;
                        wr_sel_n = 1'b0;
                        wr_data  = (f > 0) ? p_d[f-1][3] : '1;
                        wr_be    = (f > 0) ? p_be[f-1][3] : '1;
                    end
                    2: begin
                        addr     = p_wr_a[f];
                        rd_sel_n = 1'b0;
                        wr_sel_n = !p_wr_en[f];
                        wr_data  = p_d[f][0];
                        wr_be    = p_be[f][0];
                    end
                    default: begin
                        addr     = ~p_wr_a[f];
                        rd_sel_n = 1'b0;
                        wr_sel_n = 1'b0;
                        wr_data  = p_d[f][1];
                        wr_be    = p_be[f][1];
                    end
                endcase
                @(negedge clk);
            end
            for (int k = 0; k < 4; k++) exp_prev[k] = exp_cur[k];
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule